// File: doc/BRIEF.md
# Oversampled Serial Receiver with Line-Break Reporting

This block receives asynchronous serial characters of eight data bits. Each character has an optional parity bit and one stop bit. The line is sampled on a 16x oversampling enable that a separate divider supplies. A start is accepted only on a high-to-low change of the line, and it is confirmed at the middle of the start bit. Every later bit is sampled at its own middle. Received characters leave through a valid/ready stream that carries the data byte and its parity and framing error flags.

A line break is a frame in which every sampled data bit, the parity bit (when present) and the stop bit are all low. A break is not delivered as a character. Instead a sticky break status bit is raised at the stop-bit sample. While the break lasts, the receiver ignores the line until it sees two consecutive high samples. At that point the break status bit is raised a second time, so software sees one event for the start of the break and one for its end.

Four status bits (character held, break, held character has a parity error, held character has a framing error) are combined with a mask into one interrupt line. Each mask bit has its own set and clear input.

Stream rules: `m_valid_o` stays high, with data and flags stable, until a cycle in which `m_ready_i` is high. If a new character completes while the previous one is still unaccepted, the new character replaces it and `m_valid_o` stays high. Back-pressure therefore never stalls reception; the older character is lost.

Top module: `brk_uart_rx`

## Requirements
- R1: A start is confirmed only if the line is still low at the eighth tick after the falling edge was seen; otherwise no character is produced. Data bits are sampled every 16 ticks after that point and assembled least significant bit first.
- R2: `m_valid_o` rises when a character completes and stays high, with `m_data_o`, `m_perr_o` and `m_ferr_o` stable, until a cycle with `m_ready_i` high. A newer character overwrites an unaccepted one.
- R3: With `par_en_i` high, a parity bit follows the data. The expected bit is the XOR of the eight data bits when `par_odd_i` is 0, and its inverse when `par_odd_i` is 1. A mismatch sets `m_perr_o` on that character. With `par_en_i` low, `m_perr_o` is always 0.
- R4: A frame whose stop bit is sampled low but which is not a break is delivered with its data and `m_ferr_o` = 1.
- R5: A frame with all data bits low, the parity bit low (when enabled) and the stop bit low sets `brk_o` at the stop sample and produces no character.
- R6: After a break starts, no character and no error is produced while the line stays low.
- R7: The end of a break needs two consecutive high samples of the line. A single high sample does not end it. The end sets `brk_o` again.
- R8: `brk_o` is sticky. `brk_clr_i` clears it, and a break event in the same cycle wins over the clear.
- R9: `imask_set_i[i]` sets and `imask_clr_i[i]` clears mask bit i, shown on `imask_o`. A clear wins over a set in the same cycle.
- R10: `irq_o` is high when any status bit and its mask bit are both high. The status bits are: bit 0 = `m_valid_o`, bit 1 = `brk_o`, bit 2 = `m_valid_o & m_perr_o`, bit 3 = `m_valid_o & m_ferr_o`.
- R11: After a frame ends with the line low, no new start is taken until the line has been sampled high.
- R12: After reset, `m_valid_o`, `brk_o`, `imask_o` and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | Oversampling enable, 16 per bit |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | Odd parity when 1, even when 0 |
| m_data_o | output | 8 | Received character |
| m_perr_o | output | 1 | Parity error of held character |
| m_ferr_o | output | 1 | Framing error of held character |
| m_valid_o | output | 1 | Character held |
| m_ready_i | input | 1 | Consumer accepts character |
| brk_o | output | 1 | Sticky break event status |
| brk_clr_i | input | 1 | Clear break status |
| imask_set_i | input | 4 | Mask bit set strobes |
| imask_clr_i | input | 4 | Mask bit clear strobes |
| imask_o | output | 4 | Current interrupt mask |
| irq_o | output | 1 | Interrupt request |

## Verification
Every byte value is received under no parity, even parity and odd parity, which separates bit ordering, parity polarity and a stuck or swapped data bit. Frames with a wrong parity bit, a low stop bit on nonzero data, and zero data with a high odd-parity bit separate a parity error, a framing error and a true break. The break sequence is run with a one-sample high glitch and then a real high level, which tells the end-of-break filter apart from a plain edge detector. A short start glitch, back-to-back characters without acceptance, a slower tick rate and mask set/clear collisions cover start confirmation, the overwrite rule and interrupt gating.

// File: rtl/brk_uart_rx_pkg.sv
package brk_uart_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_BRK
  } rx_state_e;

  localparam int ST_VALID = 0;
  localparam int ST_BRK   = 1;
  localparam int ST_PERR  = 2;
  localparam int ST_FERR  = 3;
  localparam int NSTAT    = 4;
endpackage

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import brk_uart_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DW     = 8,
  parameter int BRK_HI = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd,
  input  logic          par_en,
  input  logic          par_odd,
  output logic          char_done,
  output logic [DW-1:0] char_data,
  output logic          char_perr,
  output logic          char_ferr,
  output logic          brk_start,
  output logic          brk_end
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DW + 1);
  localparam int HW = $clog2(BRK_HI + 1);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [BW-1:0] BLAST = BW'(DW - 1);
  localparam logic [HW-1:0] HLAST = HW'(BRK_HI - 1);

  rx_state_e     state;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bidx;
  logic [DW-1:0] shreg;
  logic [HW-1:0] hicnt;
  logic          parb;
  logic          line_prev;
  logic          rxd_m, rxd_s;
  logic          zero_frame;

  // two-flop synchronizer for the asynchronous line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_m <= 1'b1;
      rxd_s <= 1'b1;
    end else begin
      rxd_m <= rxd;
      rxd_s <= rxd_m;
    end
  end

  assign zero_frame = (shreg == '0) && !(par_en && parb) && !rxd_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      cnt       <= '0;
      bidx      <= '0;
      shreg     <= '0;
      hicnt     <= '0;
      parb      <= 1'b0;
      line_prev <= 1'b1;
      char_done <= 1'b0;
      char_data <= '0;
      char_perr <= 1'b0;
      char_ferr <= 1'b0;
      brk_start <= 1'b0;
      brk_end   <= 1'b0;
    end else begin
      char_done <= 1'b0;
      brk_start <= 1'b0;
      brk_end   <= 1'b0;
      if (tick) begin
        line_prev <= rxd_s;
        case (state)
          RX_IDLE: begin
            if (line_prev && !rxd_s) begin
              state <= RX_START;
              cnt   <= '0;
            end
          end
          RX_START: begin
            if (cnt == MID) begin
              cnt   <= '0;
              bidx  <= '0;
              state <= rxd_s ? RX_IDLE : RX_DATA;
            end else cnt <= cnt + 1'b1;
          end
          RX_DATA: begin
            if (cnt == LAST) begin
              cnt   <= '0;
              shreg <= {rxd_s, shreg[DW-1:1]};
              if (bidx == BLAST) state <= par_en ? RX_PAR : RX_STOP;
              else bidx <= bidx + 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          RX_PAR: begin
            if (cnt == LAST) begin
              cnt   <= '0;
              parb  <= rxd_s;
              state <= RX_STOP;
            end else cnt <= cnt + 1'b1;
          end
          RX_STOP: begin
            if (cnt == LAST) begin
              cnt <= '0;
              if (zero_frame) begin
                brk_start <= 1'b1;
                hicnt     <= '0;
                state     <= RX_BRK;
              end else begin
                char_done <= 1'b1;
                char_data <= shreg;
                char_perr <= par_en && (parb != ((^shreg) ^ par_odd));
                char_ferr <= !rxd_s;
                state     <= RX_IDLE;
              end
            end else cnt <= cnt + 1'b1;
          end
          RX_BRK: begin
            if (rxd_s) begin
              if (hicnt == HLAST) begin
                brk_end <= 1'b1;
                state   <= RX_IDLE;
              end else hicnt <= hicnt + 1'b1;
            end else hicnt <= '0;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({char_done, brk_start, brk_end})); // R5
  AST_BRK_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    brk_start |-> !$past(rxd_s)); // R5
  AST_BRK_END_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    brk_end |-> $past(rxd_s)); // R7
  AST_NO_PERR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && !$past(par_en)) |-> !char_perr); // R3
endmodule

// File: rtl/rx_out_hold.sv
module rx_out_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] ld_data,
  input  logic          ld_perr,
  input  logic          ld_ferr,
  input  logic          ready,
  output logic          valid,
  output logic [DW-1:0] data,
  output logic          perr,
  output logic          ferr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
      perr  <= 1'b0;
      ferr  <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= ld_data;
      perr  <= ld_perr;
      ferr  <= ld_ferr;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !load) |=> (valid && $stable(data) && $stable(perr) && $stable(ferr))); // R2
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready && !load) |=> !valid); // R2
endmodule

// File: rtl/rx_status_irq.sv
module rx_status_irq
  import brk_uart_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             brk_ev,
  input  logic             brk_clr,
  input  logic             held,
  input  logic             held_perr,
  input  logic             held_ferr,
  input  logic [NSTAT-1:0] mask_set,
  input  logic [NSTAT-1:0] mask_clr,
  output logic             brk_q,
  output logic [NSTAT-1:0] mask_q,
  output logic             irq
);
  logic [NSTAT-1:0] stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brk_q <= 1'b0;
    else if (brk_ev) brk_q <= 1'b1;
    else if (brk_clr) brk_q <= 1'b0;
  end

  for (genvar i = 0; i < NSTAT; i++) begin : g_mask
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q[i] <= 1'b0;
      else if (mask_clr[i]) mask_q[i] <= 1'b0;
      else if (mask_set[i]) mask_q[i] <= 1'b1;
    end
  end

  always_comb begin
    stat           = '0;
    stat[ST_VALID] = held;
    stat[ST_BRK]   = brk_q;
    stat[ST_PERR]  = held & held_perr;
    stat[ST_FERR]  = held & held_ferr;
  end

  assign irq = |(stat & mask_q);

  AST_BRK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_q && !brk_clr) |=> brk_q); // R8
  AST_BRK_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    brk_ev |=> brk_q); // R8
  AST_MASK_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_clr != '0) |=> ((mask_q & $past(mask_clr)) == '0)); // R9
endmodule

// File: rtl/brk_uart_rx.sv
module brk_uart_rx
  import brk_uart_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DW     = 8,
  parameter int BRK_HI = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd_i,
  input  logic             tick_i,
  input  logic             par_en_i,
  input  logic             par_odd_i,
  output logic [DW-1:0]    m_data_o,
  output logic             m_perr_o,
  output logic             m_ferr_o,
  output logic             m_valid_o,
  input  logic             m_ready_i,
  output logic             brk_o,
  input  logic             brk_clr_i,
  input  logic [NSTAT-1:0] imask_set_i,
  input  logic [NSTAT-1:0] imask_clr_i,
  output logic [NSTAT-1:0] imask_o,
  output logic             irq_o
);
  logic          c_done, c_perr, c_ferr, b_start, b_end;
  logic [DW-1:0] c_data;

  rx_frame_fsm #(.OVS(OVS), .DW(DW), .BRK_HI(BRK_HI)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .rxd(rxd_i),
    .par_en(par_en_i), .par_odd(par_odd_i),
    .char_done(c_done), .char_data(c_data), .char_perr(c_perr),
    .char_ferr(c_ferr), .brk_start(b_start), .brk_end(b_end)
  );

  rx_out_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(c_done), .ld_data(c_data),
    .ld_perr(c_perr), .ld_ferr(c_ferr), .ready(m_ready_i),
    .valid(m_valid_o), .data(m_data_o), .perr(m_perr_o), .ferr(m_ferr_o)
  );

  rx_status_irq u_stat (
    .clk(clk), .rst_n(rst_n), .brk_ev(b_start | b_end), .brk_clr(brk_clr_i),
    .held(m_valid_o), .held_perr(m_perr_o), .held_ferr(m_ferr_o),
    .mask_set(imask_set_i), .mask_clr(imask_clr_i),
    .brk_q(brk_o), .mask_q(imask_o), .irq(irq_o)
  );
endmodule

// File: tb/tb_brk_uart_rx.sv
module tb_brk_uart_rx;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       tick_i;
  logic       par_en = 1'b0, par_odd = 1'b0;
  logic [7:0] m_data;
  logic       m_perr, m_ferr, m_valid;
  logic       m_ready = 1'b0;
  logic       brk, brk_clr = 1'b0;
  logic [3:0] mset = '0, mclr = '0, imask;
  logic       irq;

  int tdiv = 1;
  int tcnt = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) tcnt <= (tcnt >= tdiv - 1) ? 0 : tcnt + 1;
  assign tick_i = (tcnt == 0);

  brk_uart_rx dut (
    .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .tick_i(tick_i),
    .par_en_i(par_en), .par_odd_i(par_odd),
    .m_data_o(m_data), .m_perr_o(m_perr), .m_ferr_o(m_ferr),
    .m_valid_o(m_valid), .m_ready_i(m_ready),
    .brk_o(brk), .brk_clr_i(brk_clr),
    .imask_set_i(mset), .imask_clr_i(mclr), .imask_o(imask), .irq_o(irq)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_ticks(int n);
    repeat (n * tdiv) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    rxd = b;
    wait_ticks(16);
  endtask

  task automatic send_frame(logic [7:0] d, logic pen, logic pb, logic sb);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    if (pen) send_bit(pb);
    send_bit(sb);
  endtask

  task automatic accept();
    m_ready = 1'b1;
    @(negedge clk);
    m_ready = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(!m_valid && !brk && imask == 4'h0 && !irq, "R12 reset",
        {m_valid, brk, imask, irq}, 0);
    wait_ticks(20);

    // R1 R3: exhaustive bytes, no / even / odd parity
    for (int cfg = 0; cfg < 3; cfg++) begin
      par_en  = (cfg != 0);
      par_odd = (cfg == 2);
      for (int d = 0; d < 256; d++) begin
        logic [7:0] b;
        logic pb;
        b  = d[7:0];
        pb = (^b) ^ par_odd;
        send_frame(b, par_en, pb, 1'b1);
        chk(m_valid && m_data == b && !m_perr && !m_ferr, "R1 R3 sweep",
            {m_valid, m_perr, m_ferr, m_data}, {3'b100, b});
        accept();
        chk(!m_valid, "R2 accept drops valid", m_valid, 0);
      end
    end

    // R3 wrong parity, even and odd
    par_en = 1'b1;
    for (int k = 0; k < 2; k++) begin
      par_odd = k[0];
      send_frame(8'h37, 1'b1, ~((^8'h37) ^ par_odd), 1'b1);
      chk(m_valid && m_perr && !m_ferr && m_data == 8'h37, "R3 parity error",
          {m_perr, m_ferr, m_data}, {2'b10, 8'h37});
      accept();
    end

    // R3 parity disabled: no parity error ever
    par_en = 1'b0;
    par_odd = 1'b1;
    send_frame(8'h01, 1'b0, 1'b0, 1'b1);
    chk(m_valid && !m_perr && m_data == 8'h01, "R3 parity off", {m_perr, m_data}, {1'b0, 8'h01});
    accept();

    // R4 framing error with nonzero data; R11 low line afterwards
    send_frame(8'hA5, 1'b0, 1'b0, 1'b0);
    chk(m_valid && m_ferr && !m_perr && m_data == 8'hA5 && !brk, "R4 framing",
        {brk, m_ferr, m_data}, {2'b01, 8'hA5});
    accept();
    wait_ticks(200);
    chk(!m_valid && !brk, "R11 no start without high", {m_valid, brk}, 0);
    rxd = 1'b1;
    wait_ticks(20);

    // R4 zero data with odd parity bit high: framing error, not break
    par_en = 1'b1;
    par_odd = 1'b1;
    send_frame(8'h00, 1'b1, 1'b1, 1'b0);
    chk(m_valid && m_ferr && !m_perr && m_data == 8'h00 && !brk, "R4 zero data not break",
        {brk, m_perr, m_ferr}, 3'b001);
    accept();
    rxd = 1'b1;
    wait_ticks(20);

    // R1 start glitch shorter than half a bit
    par_en = 1'b0;
    rxd = 1'b0;
    wait_ticks(3);
    rxd = 1'b1;
    wait_ticks(40);
    chk(!m_valid, "R1 start glitch ignored", m_valid, 0);

    // R10 interrupt on held character, R9 clear wins
    mset = 4'b0001;
    @(negedge clk);
    mset = '0;
    chk(imask == 4'b0001 && !irq, "R9 mask set", imask, 4'b0001);
    send_frame(8'h3C, 1'b0, 1'b0, 1'b1);
    chk(irq, "R10 irq on valid", irq, 1);
    mset = 4'b0001;
    mclr = 4'b0001;
    @(negedge clk);
    mset = '0;
    mclr = '0;
    chk(imask == 4'b0000 && !irq, "R9 clear wins", imask, 0);
    mset = 4'b1000;
    @(negedge clk);
    mset = '0;
    chk(!irq, "R10 ferr bit masked by flag", irq, 0);
    accept();

    // R2 back-pressure: second character overwrites the first
    send_frame(8'h5A, 1'b0, 1'b0, 1'b1);
    chk(m_valid && m_data == 8'h5A, "R2 first held", m_data, 8'h5A);
    send_frame(8'hC3, 1'b0, 1'b0, 1'b1);
    chk(m_valid && m_data == 8'hC3, "R2 overwrite", m_data, 8'hC3);
    accept();

    // R1 slower tick rate
    tdiv = 3;
    wait_ticks(4);
    par_en = 1'b1;
    par_odd = 1'b0;
    send_frame(8'h96, 1'b1, ^8'h96, 1'b1);
    chk(m_valid && m_data == 8'h96 && !m_perr, "R1 gapped ticks", m_data, 8'h96);
    accept();
    tdiv = 1;
    wait_ticks(4);

    // R5 break with parity, R10 irq on break
    mclr = 4'b1111;
    @(negedge clk);
    mclr = '0;
    mset = 4'b0010;
    @(negedge clk);
    mset = '0;
    send_frame(8'h00, 1'b1, 1'b0, 1'b0);
    chk(brk && !m_valid, "R5 break start", {brk, m_valid}, 2'b10);
    chk(irq, "R10 irq on break", irq, 1);
    wait_ticks(300);
    chk(!m_valid && brk, "R6 quiet during break", {brk, m_valid}, 2'b10);
    brk_clr = 1'b1;
    @(negedge clk);
    brk_clr = 1'b0;
    chk(!brk && !irq, "R8 clear", {brk, irq}, 0);
    // R7 single high sample does not end the break
    rxd = 1'b1;
    @(negedge clk);
    rxd = 1'b0;
    wait_ticks(40);
    chk(!brk && !m_valid, "R7 one-sample high ignored", {brk, m_valid}, 0);
    rxd = 1'b1;
    wait_ticks(6);
    chk(brk, "R7 end of break", brk, 1);
    brk_clr = 1'b1;
    @(negedge clk);
    brk_clr = 1'b0;
    chk(!brk, "R8 clear after end", brk, 0);
    wait_ticks(10);

    // R5 break without parity, then normal reception resumes
    par_en = 1'b0;
    send_frame(8'h00, 1'b0, 1'b0, 1'b0);
    chk(brk && !m_valid, "R5 break no parity", {brk, m_valid}, 2'b10);
    wait_ticks(30);
    rxd = 1'b1;
    wait_ticks(6);
    send_frame(8'h81, 1'b0, 1'b0, 1'b1);
    chk(m_valid && m_data == 8'h81 && !m_ferr, "R6 receive after break", m_data, 8'h81);
    accept();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule